// File: doc/BRIEF.md
# Flagless Shift and Rotate Unit

This block is a purely combinational execution unit for four shift-class operations on 32-bit or 64-bit data: arithmetic right shift, logical left shift, logical right shift and right rotate. None of them produces status flags. The unit drives a constant "keep flags" indication instead, so the surrounding flag logic leaves the architectural flags untouched.

The three shifts take their count from a register operand. The rotate takes its count from an 8-bit immediate. In every case the count is reduced to the low 5 bits in 32-bit mode and to the low 6 bits in 64-bit mode. In 32-bit mode the unit works on the low half of the data only and returns zeros in the upper half.

Top module: `flagless_shift_unit`

## Requirements
- R1: With `opSel`=2'b01 (logical left shift), `result` equals `dataIn` shifted left by the masked count, with zeros entering at bit 0.
- R2: With `opSel`=2'b10 (logical right shift), `result` equals the operand shifted right by the masked count, with zeros entering at the top of the selected width.
- R3: With `opSel`=2'b00 (arithmetic right shift), the vacated upper bits are copies of the sign bit of the selected width. That sign bit is bit 63 in 64-bit mode and bit 31 in 32-bit mode.
- R4: With `opSel`=2'b11 (right rotate), bits leaving at bit 0 re-enter at the top of the selected width. The count is `immIn` masked to the width, and `countIn` has no effect.
- R5: For the three shifts, `immIn` has no effect. Only `countIn[4:0]` (32-bit mode) or `countIn[5:0]` (64-bit mode) is used, so the higher count bits are ignored.
- R6: When the masked count is zero, every operation returns the operand unchanged. In 32-bit mode the operand is `dataIn[31:0]`.
- R7: When `wideSel`=0, `result[63:32]` is zero and `dataIn[63:32]` has no effect. When `wideSel`=1, all 64 bits are used.
- R8: `flagsKeep` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 2 | Operation: 00 arithmetic right, 01 left, 10 logical right, 11 rotate right |
| wideSel | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| dataIn | input | 64 | Operand to shift or rotate |
| countIn | input | 64 | Register count operand for the shifts |
| immIn | input | 8 | Immediate count for the rotate |
| result | output | 64 | Shifted or rotated value |
| flagsKeep | output | 1 | Constant indication that flags are preserved |

## Verification
The assertions check several properties on every input combination:
- the upper half is zero in 32-bit mode;
- the constant flag-preserve output;
- identity at a zero masked count;
- the sign bit surviving an arithmetic shift;
- a zero at bit 0 after a nonzero left shift;
- a zero at the top after a nonzero logical right shift.

Other behaviours only show up when the bench's scenarios compare exact result values against a bit-by-bit model. These are:
- the rotate wraparound;
- the exact count masking;
- the insensitivity to the unused count source and to the upper data half.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  localparam int DATA_W   = 64;
  localparam int NARROW_W = 32;
  localparam int IMM_W    = 8;
  localparam int WIDE_CW   = $clog2(DATA_W);
  localparam int NARROW_CW = $clog2(NARROW_W);

  typedef enum logic [1:0] {
    OP_SAR = 2'b00,
    OP_SHL = 2'b01,
    OP_SHR = 2'b10,
    OP_ROR = 2'b11
  } shift_op_e;

  typedef struct packed {
    shift_op_e          op;
    logic               wide;
    logic [WIDE_CW-1:0] cnt;
  } shift_ctrl_t;
endpackage

// File: rtl/shift_lane.sv
module shift_lane
  import shift_unit_pkg::*;
#(
  parameter int W  = 64,
  parameter int CW = $clog2(W)
) (
  input  shift_op_e       op,
  input  logic [W-1:0]    dIn,
  input  logic [CW-1:0]   cnt,
  output logic [W-1:0]    dOut
);
  logic [CW:0] backCnt;

  always_comb begin
    backCnt = (CW+1)'(W) - {1'b0, cnt};
    case (op)
      OP_SAR:  dOut = W'($signed(dIn) >>> cnt);
      OP_SHL:  dOut = dIn << cnt;
      OP_SHR:  dOut = dIn >> cnt;
      default: dOut = (dIn >> cnt) | (dIn << backCnt);
    endcase
  end
endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_unit_pkg::*;
(
  input  logic [1:0]        opSel,
  input  logic              wideSel,
  input  logic [DATA_W-1:0] countIn,
  input  logic [IMM_W-1:0]  immIn,
  output shift_ctrl_t       ctrl,
  output logic              flagsKeep
);
  localparam logic [WIDE_CW-1:0] WIDE_MASK   = '1;
  localparam logic [WIDE_CW-1:0] NARROW_MASK = WIDE_CW'((1 << NARROW_CW) - 1);

  logic [WIDE_CW-1:0] rawCnt;

  always_comb begin
    ctrl.op   = shift_op_e'(opSel);
    ctrl.wide = wideSel;
    if (ctrl.op == OP_ROR) rawCnt = immIn[WIDE_CW-1:0];
    else                   rawCnt = countIn[WIDE_CW-1:0];
    ctrl.cnt  = rawCnt & (wideSel ? WIDE_MASK : NARROW_MASK);
  end

  assign flagsKeep = 1'b1;
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_unit_pkg::*;
(
  input  shift_ctrl_t       ctrl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] result
);
  localparam int NUM_LANES = 2;
  localparam int LANE_W [NUM_LANES] = '{NARROW_W, DATA_W};

  logic [DATA_W-1:0] laneOut [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW  = LANE_W[g];
    localparam int LCW = $clog2(LW);
    logic [LW-1:0] lres;
    shift_lane #(.W(LW), .CW(LCW)) u_lane (
      .op  (ctrl.op),
      .dIn (dataIn[LW-1:0]),
      .cnt (ctrl.cnt[LCW-1:0]),
      .dOut(lres)
    );
    assign laneOut[g] = DATA_W'(lres);
  end

  assign result = ctrl.wide ? laneOut[1] : laneOut[0];
endmodule

// File: rtl/flagless_shift_unit.sv
module flagless_shift_unit
  import shift_unit_pkg::*;
(
  input  logic [1:0]        opSel,
  input  logic              wideSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] countIn,
  input  logic [IMM_W-1:0]  immIn,
  output logic [DATA_W-1:0] result,
  output logic              flagsKeep
);
  shift_ctrl_t ctrl;

  shift_ctrl u_ctrl (
    .opSel    (opSel),
    .wideSel  (wideSel),
    .countIn  (countIn),
    .immIn    (immIn),
    .ctrl     (ctrl),
    .flagsKeep(flagsKeep)
  );

  shift_datapath u_dp (
    .ctrl  (ctrl),
    .dataIn(dataIn),
    .result(result)
  );
endmodule

// File: rtl/flagless_shift_unit_chk.sv
module flagless_shift_unit_chk
  import shift_unit_pkg::*;
(
  input logic [1:0]        opSel,
  input logic              wideSel,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] countIn,
  input logic [IMM_W-1:0]  immIn,
  input logic [DATA_W-1:0] result,
  input logic              flagsKeep
);
  int unsigned effCnt;
  int unsigned topBit;
  logic [DATA_W-1:0] opnd;

  always_comb begin
    topBit = wideSel ? DATA_W - 1 : NARROW_W - 1;
    effCnt = int'(opSel == 2'b11 ? {56'd0, immIn} : countIn) & topBit;
    opnd   = wideSel ? dataIn : {{(DATA_W-NARROW_W){1'b0}}, dataIn[NARROW_W-1:0]};
    if (!$isunknown({opSel, wideSel, dataIn, countIn, immIn, result})) begin
      p_flags_keep_r8: assert (flagsKeep == 1'b1);
      if (!wideSel) begin
        p_upper_zero_r7: assert (result[DATA_W-1:NARROW_W] == '0);
      end
      if (effCnt == 0) begin
        p_zero_count_r6: assert (result == opnd);
      end
      if (opSel == 2'b00) begin
        p_sign_kept_r3: assert (result[topBit] == dataIn[topBit]);
      end
      if (opSel == 2'b01 && effCnt != 0) begin
        p_shl_lsb_r1: assert (result[0] == 1'b0);
      end
      if (opSel == 2'b10 && effCnt != 0) begin
        p_shr_msb_r2: assert (result[topBit] == 1'b0);
      end
    end
  end
endmodule

bind flagless_shift_unit flagless_shift_unit_chk u_chk (
  .opSel    (opSel),
  .wideSel  (wideSel),
  .dataIn   (dataIn),
  .countIn  (countIn),
  .immIn    (immIn),
  .result   (result),
  .flagsKeep(flagsKeep)
);

// File: tb/flagless_shift_unit_tb.sv
module flagless_shift_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic        wideSel = 1'b0;
  logic [63:0] dataIn = '0;
  logic [63:0] countIn = '0;
  logic [7:0]  immIn = '0;
  logic [63:0] result;
  logic        flagsKeep;
  int checks = 0;
  int failures = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  flagless_shift_unit u_dut (
    .opSel(opSel), .wideSel(wideSel), .dataIn(dataIn), .countIn(countIn),
    .immIn(immIn), .result(result), .flagsKeep(flagsKeep)
  );

  // Bit-by-bit model written from the requirements.
  function automatic logic [63:0] model(input logic [1:0] op, input logic wd,
      input logic [63:0] d, input logic [63:0] c, input logic [7:0] im);
    int w = wd ? 64 : 32;
    int n = (op == 2'b11) ? int'(im) % w : int'(c[7:0]) % w;
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) begin
      int s;
      case (op)
        2'b01: begin s = i - n; r[i] = (s >= 0) ? d[s] : 1'b0; end
        2'b10: begin s = i + n; r[i] = (s < w) ? d[s] : 1'b0; end
        2'b00: begin s = i + n; r[i] = (s < w) ? d[s] : d[w-1]; end
        default: begin s = (i + n) % w; r[i] = d[s]; end
      endcase
    end
    return r;
  endfunction

  task automatic apply(input logic [1:0] op, input logic wd, input logic [63:0] d,
      input logic [63:0] c, input logic [7:0] im);
    @(negedge clk);
    opSel = op; wideSel = wd; dataIn = d; countIn = c; immIn = im;
    #(CLK_PERIOD/4);
  endtask

  task automatic expect64(input string req, input logic [63:0] exp);
    checks++;
    if (result !== exp) begin
      failures++;
      $display("FAIL %s op=%0d wide=%0b actual=%h expected=%h", req, opSel, wideSel, result, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] op, input logic wd,
      input logic [63:0] d, input logic [63:0] c, input logic [7:0] im);
    apply(op, wd, d, c, im);
    expect64(req, model(op, wd, d, c, im));
  endtask

  task automatic t_idle;
    apply(2'b00, 1'b0, '0, '0, '0);
    expect64("idle", 64'd0);
  endtask

  task automatic t_shl_r1;
    apply(2'b01, 1'b1, 64'h8000_0000_0000_0001, 64'd4, 8'd0);
    expect64("R1", 64'h0000_0000_0000_0010);
    apply(2'b01, 1'b0, 64'h0000_0000_8000_0001, 64'd33, 8'd0);
    expect64("R1", 64'h0000_0000_0000_0002);
    run("R1", 2'b01, 1'b1, 64'h0123_4567_89AB_CDEF, 64'd63, 8'd0);
  endtask

  task automatic t_shr_r2;
    apply(2'b10, 1'b1, 64'hF000_0000_0000_0000, 64'd60, 8'd0);
    expect64("R2", 64'h0000_0000_0000_000F);
    apply(2'b10, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'd31, 8'd0);
    expect64("R2", 64'h0000_0000_0000_0001);
  endtask

  task automatic t_sar_r3;
    apply(2'b00, 1'b1, 64'h8000_0000_0000_0000, 64'd4, 8'd0);
    expect64("R3", 64'hF800_0000_0000_0000);
    apply(2'b00, 1'b0, 64'h0000_0000_8000_0000, 64'd8, 8'd0);
    expect64("R3", 64'h0000_0000_FF80_0000);
    apply(2'b00, 1'b0, 64'hFFFF_FFFF_7000_0000, 64'd4, 8'd0);
    expect64("R3", 64'h0000_0000_0700_0000);
  endtask

  task automatic t_ror_r4;
    apply(2'b11, 1'b1, 64'h0000_0000_0000_0001, 64'd0, 8'd1);
    expect64("R4", 64'h8000_0000_0000_0000);
    apply(2'b11, 1'b0, 64'h0000_0000_0000_00FF, 64'd0, 8'd36);
    expect64("R4", 64'h0000_0000_F000_000F);
    apply(2'b11, 1'b1, 64'h0000_0000_0000_0003, 64'd5, 8'd0);
    expect64("R4", 64'h0000_0000_0000_0003);
  endtask

  task automatic t_ignore_r5;
    apply(2'b10, 1'b1, 64'h0000_0000_0000_0100, 64'hFFFF_FF00_0000_0044, 8'd7);
    expect64("R5", 64'h0000_0000_0000_0010);
    apply(2'b01, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0025, 8'd9);
    expect64("R5", 64'h0000_0000_0000_0020);
  endtask

  task automatic t_zero_r6;
    for (int op = 0; op < 4; op++) begin
      apply(2'(op), 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 64'd64, 8'd128);
      expect64("R6", 64'hDEAD_BEEF_CAFE_F00D);
      apply(2'(op), 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 64'd32, 8'd32);
      expect64("R6", 64'h0000_0000_CAFE_F00D);
    end
  endtask

  task automatic t_narrow_r7;
    apply(2'b01, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'd4, 8'd0);
    expect64("R7", 64'h0000_0000_0000_0010);
    apply(2'b10, 1'b0, 64'hAAAA_AAAA_0000_0000, 64'd1, 8'd0);
    expect64("R7", 64'd0);
  endtask

  task automatic t_flags_r8;
    checks++;
    if (flagsKeep !== 1'b1) begin
      failures++;
      $display("FAIL R8 actual=%b expected=1", flagsKeep);
    end
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      run("R1/R2/R3/R4 sweep", lfsr[1:0], lfsr[2], {lfsr[31:0], lfsr[63:32]} ^ lfsr,
          {56'd0, lfsr[15:8]}, lfsr[23:16]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 10000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    t_idle();
    t_flags_r8();
    t_shl_r1();
    t_shr_r2();
    t_sar_r3();
    t_ror_r4();
    t_ignore_r5();
    t_zero_r6();
    t_narrow_r7();
    t_sweep();
    t_flags_r8();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule